// File: doc/BRIEF.md
# Dual-Mode Dual-Clock FIFO

This block is a parameterized FIFO that carries words between two clock domains. A producer pushes words on the write clock with an active-low write enable. A consumer takes them on the read clock through a registered output with an active-low read enable. The two clocks may be unrelated, or they may be one and the same clock. Each side keeps its own binary and Gray-coded pointer. The Gray value crosses into the other domain through a two-flop synchronizer. Each pointer carries one extra wrap bit so that the full and empty states can be told apart.

The read discipline is chosen by `fwft_sel` while reset is held, and it stays fixed until the next reset. In standard mode the consumer must request every word, including the first word written into an empty FIFO. The two status pins then act as an active-low full flag and an active-low empty flag. In fall-through mode the head word moves into the output register without any request. The output register then counts as one more storage slot. The status pins act as "no space" on the write side and "no valid word" on the read side. Both are high when set.

`DEPTH` must be a power of two and at least 4. `rst_n` is a synchronous active-low reset. It must be held low for at least two edges of each clock.

Top module: `dcf_fifo`

## Requirements
- R1: In either mode, a write while the write side reports no space and a read while no word is available are both ignored: no stored word is overwritten and `dout` does not change.
- R2: While `ren_n` is high, `dout` keeps its value: in standard mode always, and in fall-through mode whenever a valid word is being presented.
- R3: In standard mode no word reaches `dout` without a read with `ren_n` low, the first word after empty included. `rd_flag` is 0 when empty and drops at the read edge that takes the last stored word.
- R4: In standard mode after reset, `wr_flag` stays 1 for the first DEPTH-1 writes and is 0 right after the DEPTH-th write when there are no reads.
- R5: In fall-through mode after reset, `wr_flag` is still 0 after DEPTH writes and becomes 1 only after write DEPTH+1 when there are no reads.
- R6: In fall-through mode, a word written into an empty FIFO appears on `dout` at the third rising `rd_clk` edge after its write edge. `rd_flag` falls from 1 to 0 at that same edge. No read enable is needed.
- R7: In fall-through mode, `rd_flag` returns to 1 only at a read edge with `ren_n` low that takes the last word. That word stays on `dout`.
- R8: A read that frees space releases the write-side flag at the second `wr_clk` edge after the read. In standard mode, a write into an empty FIFO releases `rd_flag` to 1 at the second `rd_clk` edge after the write.
- R9: `fwft_sel` is sampled only while `rst_n` is low. Changing it after reset does not change the read discipline.
- R10: After reset, standard mode shows `wr_flag`=1, `rd_flag`=0, `dout`=0. Fall-through mode shows `wr_flag`=0, `rd_flag`=1, `dout`=0.
- R11: Words leave in the order they were written, also across pointer wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| rst_n | input | 1 | Synchronous active-low master reset, applied in both domains |
| fwft_sel | input | 1 | Mode select sampled during reset: 0 standard, 1 fall-through |
| wen_n | input | 1 | Active-low write enable |
| din | input | DATA_W | Write data |
| wr_flag | output | 1 | Standard: 0 when full. Fall-through: 1 when no space |
| ren_n | input | 1 | Active-low read enable |
| dout | output | DATA_W | Registered read data |
| rd_flag | output | 1 | Standard: 0 when empty. Fall-through: 1 when no valid word |

## Verification
Some properties are checked on every cycle by the embedded assertions. The occupancy seen by each side never goes beyond DEPTH or below zero. The output holds while reads are withheld. The read that takes the last word in fall-through mode clears the valid state and leaves the data alone. Each Gray pointer changes by at most one bit per edge. Other behaviours can only be shown by the directed scenarios: the exact write counts at which the flags set in each mode, the three-edge fall-through latency, the two-edge release of both flags, that the mode is frozen after reset, and that data order holds through wrap-around.

// File: rtl/dcf_pkg.sv
// Shared types for the dual-mode dual-clock FIFO.
package dcf_pkg;

    // Read discipline latched at master reset.
    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } dcf_mode_e;

endpackage

// File: rtl/dcf_sync.sv
// Two-flop synchronizer for a Gray-coded pointer, plus its binary value.
// Assumes the source changes by at most one bit per source-clock edge.
module dcf_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] gray_out,
    output logic [W-1:0] bin_out
);

    logic [W-1:0] stage1;

    // Two-stage capture of the foreign pointer in the local domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1   <= '0;
            gray_out <= '0;
        end else begin
            stage1   <= gray_in;
            gray_out <= stage1;
        end
    end

    // Gray to binary: each bit is the parity of the bits at and above it.
    always_comb begin
        for (int i = 0; i < W; i++) begin
            bin_out[i] = ^(gray_out >> i);
        end
    end

endmodule

// File: rtl/dcf_mem.sv
// Storage array: written on the write clock, read without a clock.
// Assumes the read side registers the data it takes.
module dcf_mem #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] cells [DEPTH];

    // Store one word on each accepted write.
    always_ff @(posedge wclk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/dcf_wr_ctrl.sv
// Write-side control: pointer, full detection and the write status pin.
// Assumes DEPTH is a power of two and at least 4. The read pointer arrives
// already synchronized to the write clock.
module dcf_wr_ctrl
    import dcf_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fwft_sel,
    input  logic          wen_n,
    input  logic [PW-1:0] rgray_sync,
    input  logic [PW-1:0] rbin_sync,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [PW-1:0] wgray,
    output logic          wr_flag
);

    dcf_mode_e     mode_q;
    logic [PW-1:0] wbin;
    logic [PW-1:0] wbin_nx;
    logic          full;
    logic [PW-1:0] wcount;

    // Latch the read discipline while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= dcf_mode_e'(fwft_sel);
        end
    end

    // Full when the pointers differ only in their two top Gray bits.
    assign full    = (wgray == {~rgray_sync[PW-1:PW-2], rgray_sync[PW-3:0]});
    assign we      = !wen_n && !full;
    assign wbin_nx = wbin + 1'b1;
    assign waddr   = wbin[AW-1:0];

    // Advance the binary and Gray write pointers on each accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (we) begin
            wbin  <= wbin_nx;
            wgray <= wbin_nx ^ (wbin_nx >> 1);
        end
    end

    // Standard mode reports not-full high; fall-through reports no-space high.
    assign wr_flag = (mode_q == MODE_FWFT) ? full : !full;

    assign wcount = wbin - rbin_sync;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        wcount <= PW'(DEPTH)); // R1

    AST_WGRAY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !wen_n |=> $countones(wgray ^ $past(wgray)) <= 1); // R8

endmodule

// File: rtl/dcf_rd_ctrl.sv
// Read-side control: pointer, empty detection, output register and the
// read status pin for both disciplines. Assumes the write pointer arrives
// already synchronized to the read clock.
module dcf_rd_ctrl
    import dcf_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fwft_sel,
    input  logic              ren_n,
    input  logic [PW-1:0]     wgray_sync,
    input  logic [PW-1:0]     wbin_sync,
    input  logic [DATA_W-1:0] rdata,
    output logic [AW-1:0]     raddr,
    output logic [PW-1:0]     rgray,
    output logic [DATA_W-1:0] dout,
    output logic              rd_flag
);

    dcf_mode_e     mode_q;
    logic [PW-1:0] rbin;
    logic [PW-1:0] rbin_nx;
    logic          mem_empty;
    logic          out_valid;
    logic          take;
    logic          is_fwft;
    logic [PW-1:0] rcount;

    // Latch the read discipline while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= dcf_mode_e'(fwft_sel);
        end
    end

    assign is_fwft   = (mode_q == MODE_FWFT);
    assign mem_empty = (rgray == wgray_sync);
    assign rbin_nx   = rbin + 1'b1;
    assign raddr     = rbin[AW-1:0];

    // Standard mode fetches on request; fall-through refills an idle or consumed output.
    assign take = !mem_empty && (is_fwft ? (!out_valid || !ren_n) : !ren_n);

    // Move the head word into the output register and track its validity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbin      <= '0;
            rgray     <= '0;
            dout      <= '0;
            out_valid <= 1'b0;
        end else if (take) begin
            rbin      <= rbin_nx;
            rgray     <= rbin_nx ^ (rbin_nx >> 1);
            dout      <= rdata;
            out_valid <= is_fwft;
        end else if (!ren_n) begin
            out_valid <= 1'b0;
        end
    end

    // Standard mode reports not-empty high; fall-through reports no-word high.
    assign rd_flag = is_fwft ? !out_valid : !mem_empty;

    assign rcount = wbin_sync - rbin;

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        rcount <= PW'(DEPTH)); // R1

    AST_STD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_fwft && ren_n) |=> $stable(dout)); // R2

    AST_FWFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (is_fwft && out_valid && ren_n) |=> $stable(dout)); // R2

    AST_LAST_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (is_fwft && out_valid && !ren_n && mem_empty) |=> (!out_valid && $stable(dout))); // R7

    AST_RGRAY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !ren_n |=> $countones(rgray ^ $past(rgray)) <= 1); // R8

endmodule

// File: rtl/dcf_fifo.sv
// Dual-mode dual-clock FIFO top: ties the write side, read side, storage
// and the two pointer synchronizers together. Assumes rst_n is held low
// for at least two edges of each clock and that DEPTH is a power of two >= 4.
module dcf_fifo #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              fwft_sel,
    input  logic              wen_n,
    input  logic [DATA_W-1:0] din,
    output logic              wr_flag,
    input  logic              ren_n,
    output logic [DATA_W-1:0] dout,
    output logic              rd_flag
);

    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic              we;
    logic [AW-1:0]     waddr;
    logic [AW-1:0]     raddr;
    logic [DATA_W-1:0] rdata;
    logic [PW-1:0]     wgray;
    logic [PW-1:0]     rgray;
    logic [PW-1:0]     wgray_rs;
    logic [PW-1:0]     wbin_rs;
    logic [PW-1:0]     rgray_ws;
    logic [PW-1:0]     rbin_ws;

    dcf_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
        .clk        (wr_clk),
        .rst_n      (rst_n),
        .fwft_sel   (fwft_sel),
        .wen_n      (wen_n),
        .rgray_sync (rgray_ws),
        .rbin_sync  (rbin_ws),
        .we         (we),
        .waddr      (waddr),
        .wgray      (wgray),
        .wr_flag    (wr_flag)
    );

    dcf_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
        .wclk  (wr_clk),
        .we    (we),
        .waddr (waddr),
        .wdata (din),
        .raddr (raddr),
        .rdata (rdata)
    );

    dcf_sync #(.W(PW)) u_w2r (
        .clk      (rd_clk),
        .rst_n    (rst_n),
        .gray_in  (wgray),
        .gray_out (wgray_rs),
        .bin_out  (wbin_rs)
    );

    dcf_sync #(.W(PW)) u_r2w (
        .clk      (wr_clk),
        .rst_n    (rst_n),
        .gray_in  (rgray),
        .gray_out (rgray_ws),
        .bin_out  (rbin_ws)
    );

    dcf_rd_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rd (
        .clk        (rd_clk),
        .rst_n      (rst_n),
        .fwft_sel   (fwft_sel),
        .ren_n      (ren_n),
        .wgray_sync (wgray_rs),
        .wbin_sync  (wbin_rs),
        .rdata      (rdata),
        .raddr      (raddr),
        .rgray      (rgray),
        .dout       (dout),
        .rd_flag    (rd_flag)
    );

endmodule

// File: tb/test_dcf_fifo.sv
module test_dcf_fifo;

    localparam int DW    = 16;
    localparam int DEPTH = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fwft_sel = 1'b0;
    logic          wen_n = 1'b1;
    logic          ren_n = 1'b1;
    logic [DW-1:0] din = '0;
    logic          wr_flag;
    logic          rd_flag;
    logic [DW-1:0] dout;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    dcf_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) i_dcf_fifo (
        .wr_clk   (clk),
        .rd_clk   (clk),
        .rst_n    (rst_n),
        .fwft_sel (fwft_sel),
        .wen_n    (wen_n),
        .din      (din),
        .wr_flag  (wr_flag),
        .ren_n    (ren_n),
        .dout     (dout),
        .rd_flag  (rd_flag)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset(input logic fw);
        @(negedge clk);
        rst_n = 1'b0; fwft_sel = fw; wen_n = 1'b1; ren_n = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Reset state in both modes.
    task automatic t_reset();
        do_reset(1'b0);
        chk("R10 std wr_flag", wr_flag, 1);
        chk("R10 std rd_flag", rd_flag, 0);
        chk("R10 std dout", dout, 0);
        do_reset(1'b1);
        chk("R10 fwft wr_flag", wr_flag, 0);
        chk("R10 fwft rd_flag", rd_flag, 1);
        chk("R10 fwft dout", dout, 0);
    endtask

    // Standard first word: two-edge empty release, explicit fetch, frozen mode.
    task automatic t_std_first();
        do_reset(1'b0);
        fwft_sel = 1'b1;
        din = 16'hA5A5; wen_n = 1'b0;
        step(); wen_n = 1'b1;
        chk("R8 empty held after write edge", rd_flag, 0);
        step();
        chk("R8 empty held one edge later", rd_flag, 0);
        step();
        chk("R8 empty released second edge", rd_flag, 1);
        repeat (3) step();
        chk("R3 R9 no fall-through in standard", dout, 0);
        ren_n = 1'b0; step(); ren_n = 1'b1;
        chk("R3 word after read", dout, 16'hA5A5);
        chk("R3 empty after last read", rd_flag, 0);
        ren_n = 1'b0; step(); ren_n = 1'b1;
        chk("R1 read on empty ignored", dout, 16'hA5A5);
    endtask

    // Standard fill to DEPTH, ignored extra write, full release and drain order.
    task automatic t_std_fill();
        do_reset(1'b0);
        for (int i = 0; i < DEPTH; i++) begin
            din = DW'(16'h0100 + i); wen_n = 1'b0;
            step();
            if (i == DEPTH - 2) chk("R4 not full at DEPTH-1", wr_flag, 1);
            if (i == DEPTH - 1) chk("R4 full at DEPTH", wr_flag, 0);
        end
        din = 16'hDEAD; step(); wen_n = 1'b1;
        chk("R1 still full after extra write", wr_flag, 0);
        ren_n = 1'b0; step(); ren_n = 1'b1;
        chk("R11 first word", dout, 16'h0100);
        chk("R8 full held after read edge", wr_flag, 0);
        step();
        chk("R8 full held one edge later", wr_flag, 0);
        step();
        chk("R8 full released second edge", wr_flag, 1);
        ren_n = 1'b0;
        for (int i = 1; i < DEPTH; i++) begin
            step();
            chk("R11 std drain order", dout, 32'(16'h0100 + i));
        end
        ren_n = 1'b1;
        chk("R3 empty after drain", rd_flag, 0);
        ren_n = 1'b0; step(); ren_n = 1'b1;
        chk("R1 extra write never stored", dout, 32'(16'h0100 + DEPTH - 1));
    endtask

    // Order across pointer wrap-around in standard mode.
    task automatic t_wrap();
        do_reset(1'b0);
        for (int r = 0; r < 3; r++) begin
            for (int i = 0; i < 10; i++) begin
                din = DW'(r * 64 + i); wen_n = 1'b0; step();
            end
            wen_n = 1'b1;
            repeat (3) step();
            ren_n = 1'b0;
            for (int i = 0; i < 10; i++) begin
                step();
                chk("R11 wrap order", dout, 32'(r * 64 + i));
            end
            ren_n = 1'b1;
        end
    endtask

    // Fall-through latency, hold and last-word behaviour.
    task automatic t_fwft_first();
        do_reset(1'b1);
        din = 16'h1234; wen_n = 1'b0;
        step(); wen_n = 1'b1;
        chk("R6 not ready at write edge", rd_flag, 1);
        step();
        chk("R6 not ready first edge", rd_flag, 1);
        step();
        chk("R6 not ready second edge", rd_flag, 1);
        step();
        chk("R6 ready third edge", rd_flag, 0);
        chk("R6 word at third edge", dout, 16'h1234);
        din = 16'h5678; wen_n = 1'b0; step(); wen_n = 1'b1;
        repeat (5) step();
        chk("R2 head held while ren_n high", dout, 16'h1234);
        ren_n = 1'b0; step(); ren_n = 1'b1;
        chk("R11 fwft next word", dout, 16'h5678);
        chk("R7 still ready", rd_flag, 0);
        ren_n = 1'b0; step(); ren_n = 1'b1;
        chk("R7 not ready after last read", rd_flag, 1);
        chk("R7 last word kept", dout, 16'h5678);
        ren_n = 1'b0; step(); ren_n = 1'b1;
        chk("R1 fwft read on empty ignored", dout, 16'h5678);
    endtask

    // Fall-through capacity of DEPTH+1 and ordered drain.
    task automatic t_fwft_fill();
        do_reset(1'b1);
        for (int i = 0; i <= DEPTH; i++) begin
            din = DW'(16'h0200 + i); wen_n = 1'b0;
            step();
            if (i == DEPTH - 1) chk("R5 space after DEPTH", wr_flag, 0);
            if (i == DEPTH)     chk("R5 no space after DEPTH+1", wr_flag, 1);
        end
        din = 16'hBEEF; step(); wen_n = 1'b1;
        repeat (3) step();
        chk("R11 fwft head", dout, 16'h0200);
        ren_n = 1'b0;
        for (int i = 1; i <= DEPTH; i++) begin
            step();
            chk("R11 fwft drain order", dout, 32'(16'h0200 + i));
        end
        step(); ren_n = 1'b1;
        chk("R7 not ready after drain", rd_flag, 1);
        chk("R7 last drained word kept", dout, 32'(16'h0200 + DEPTH));
        ren_n = 1'b0; step(); ren_n = 1'b1;
        chk("R1 fwft extra write never stored", rd_flag, 1);
    endtask

    initial begin
        t_reset();
        t_std_first();
        t_std_fill();
        t_wrap();
        t_fwft_first();
        t_fwft_fill();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule